// File: doc/BRIEF.md
# Write-Through Snooping Data Cache

This block is a direct-mapped data cache for one processor among several that share one memory bus. Loads that find their word in the cache are answered locally; loads that miss, and every store, must first obtain the shared bus from an external arbiter through a request/grant pair. They then run one read or write transaction on the memory-side handshake. Stores always reach memory. A store that hits also refreshes the cached word. A store that misses leaves the cache contents alone.

Each line holds one word and carries a single valid bit; there are no ownership states. The cache watches a snoop port that reports every write seen on the shared bus together with the identity of the cache that issued it. When a write from another cache matches a valid line, that line is cleared. The next local load of that address then misses and fetches the current value from memory. Because memory is always up to date, a snooped write never needs data supplied by this cache.

The processor holds its request until a one-cycle ready pulse, which carries the load data. The bus request is held from the first arbitration cycle until memory acknowledges.

Top module: `wtSnoopCache`

## Requirements
- R1: After reset every line is invalid, `busReq`, `memReq` and `cpuReady` are low, and the first load of any address goes to the bus.
- R2: A load that hits raises `cpuReady` in the cycle after the request is seen, returns the cached word and never raises `busReq`.
- R3: A load that misses raises `busReq`, waits for `busGrant`, and issues a memory read with `memWe` low and `memAddr` equal to the load address. It fills the line from `memRdata` and returns that word with `cpuReady` in the cycle after `memAck`.
- R4: Every store, hit or miss, raises `busReq` and does not raise `memReq` until `busGrant` is high. It then issues a memory write with `memWe` high and the store address and data, and ends with `cpuReady` in the cycle after `memAck`.
- R5: A store that hits updates the cached word, so a following load of that address hits and returns the stored data without using the bus.
- R6: A store that misses does not allocate a line, so a following load of that address misses.
- R7: A snooped write whose `snoopSrc` differs from `CACHE_ID` and whose address matches a valid line invalidates it, so the next load of that address misses and returns the value held in memory.
- R8: A snooped write to an address not held in the cache, including one with the same index but a different tag, leaves the line valid. A snooped write whose `snoopSrc` equals `CACHE_ID` also leaves the line valid.
- R9: Once `memReq` is high it stays high, with `memAddr`, `memWe` and `memWdata` unchanged, until the cycle that carries `memAck`.
- R10: `cpuReady` is a pulse that lasts exactly one cycle per request.
- R11: The line index is the low `IDX_W` address bits and the tag is the remaining upper bits. A miss fill replaces whatever address previously occupied that index, and the displaced address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Load data, valid with `cpuReady` |
| busReq | output | 1 | Request for the shared bus |
| busGrant | input | 1 | Bus granted by the arbiter, held while `busReq` is high |
| memReq | output | 1 | Memory transaction in progress |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory completion, one cycle |
| memRdata | input | DATA_W | Memory read data, valid with `memAck` |
| snoopValid | input | 1 | A write is visible on the shared bus |
| snoopAddr | input | ADDR_W | Address of the snooped write |
| snoopSrc | input | SRC_W | Identity of the cache that issued the snooped write |

## Verification
A valid bit left set after a foreign write shows up on the very next load of that address. `cpuReady` arrives one cycle after the request with no bus activity and with stale data, instead of a bus read. A line wrongly allocated by a store miss, or wrongly dropped by its own or an unrelated snoop, appears the same way: the next load uses the bus when it should not, or the reverse. A corrupted tag or data word is exposed by the returned value at the first load of that index. A fault in the sequencing shows on the very cycle it happens: `memReq` without a grant, an address that changes before the acknowledge, or a ready pulse that lasts two cycles.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_MEM,
    ST_RESP
  } ctrlState_t;

  typedef struct packed {
    logic lookupLatch;
    logic hitLoad;
    logic fillLoad;
    logic storeUpd;
  } dpStrobe_t;

endpackage

// File: rtl/wtCacheCtrl.sv
module wtCacheCtrl
  import wt_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       lookupHit,
  input  logic       reqWe,
  input  logic       busGrant,
  input  logic       memAck,
  output dpStrobe_t  stb,
  output logic       busReq,
  output logic       memReq,
  output logic       memWe,
  output logic       cpuReady
);

  ctrlState_t stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    stb = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq) begin
          stb.lookupLatch = 1'b1;
          if (!cpuWe && lookupHit) begin
            stb.hitLoad = 1'b1;
            stateNext   = ST_RESP;
          end else begin
            stateNext = ST_ARB;
          end
        end
      end
      ST_ARB: begin
        if (busGrant) stateNext = ST_MEM;
      end
      ST_MEM: begin
        if (memAck) begin
          stb.fillLoad = !reqWe;
          stb.storeUpd = reqWe;
          stateNext    = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  assign busReq   = (stateQ == ST_ARB) || (stateQ == ST_MEM);
  assign memReq   = (stateQ == ST_MEM);
  assign memWe    = memReq && reqWe;
  assign cpuReady = (stateQ == ST_RESP);

  // R4
  grant_before_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busGrant);

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R2
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cpuReq && !cpuWe && lookupHit) |=> (cpuReady && !busReq));

  // R3
  miss_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cpuReq && !cpuWe && !lookupHit) |=> (busReq && !cpuReady));

  // R4
  store_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cpuReq && cpuWe) |=> (busReq && !memReq));

endmodule

// File: rtl/wtCacheData.sv
module wtCacheData
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 3,
  parameter int SRC_W    = 2,
  parameter int CACHE_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [SRC_W-1:0]  snoopSrc,
  output logic              lookupHit,
  output logic              reqWe,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [SRC_W-1:0] SELF_ID = SRC_W'(CACHE_ID);

  logic [LINES-1:0]  validQ, validNext;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];

  logic [ADDR_W-1:0] reqAddrQ;
  logic [DATA_W-1:0] reqWdataQ;
  logic              reqWeQ;
  logic [DATA_W-1:0] rdataQ;

  logic [IDX_W-1:0] cpuIdx, reqIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, reqTag, snpTag;
  logic             reqHit, snoopInv;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign reqIdx = reqAddrQ[IDX_W-1:0];
  assign reqTag = reqAddrQ[ADDR_W-1:IDX_W];
  assign snpIdx = snoopAddr[IDX_W-1:0];
  assign snpTag = snoopAddr[ADDR_W-1:IDX_W];

  assign lookupHit = validQ[cpuIdx] && (tagQ[cpuIdx] == cpuTag);
  assign reqHit    = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign snoopInv  = snoopValid && (snoopSrc != SELF_ID) &&
                     validQ[snpIdx] && (tagQ[snpIdx] == snpTag);

  // per-line state: a foreign write clears, a fill sets, otherwise hold
  for (genvar g = 0; g < LINES; g++) begin : gLine
    assign validNext[g] = (snoopInv && snpIdx == IDX_W'(g))       ? 1'b0 :
                          (stb.fillLoad && reqIdx == IDX_W'(g))   ? 1'b1 :
                          validQ[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else       validQ <= validNext;
  end

  always_ff @(posedge clk) begin
    if (stb.fillLoad) begin
      tagQ[reqIdx]  <= reqTag;
      dataQ[reqIdx] <= memRdata;
    end else if (stb.storeUpd && reqHit) begin
      dataQ[reqIdx] <= reqWdataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWdataQ <= '0;
      reqWeQ    <= 1'b0;
      rdataQ    <= '0;
    end else begin
      if (stb.lookupLatch) begin
        reqAddrQ  <= cpuAddr;
        reqWdataQ <= cpuWdata;
        reqWeQ    <= cpuWe;
      end
      if (stb.hitLoad)       rdataQ <= dataQ[cpuIdx];
      else if (stb.fillLoad) rdataQ <= memRdata;
    end
  end

  assign reqWe    = reqWeQ;
  assign reqAddr  = reqAddrQ;
  assign reqWdata = reqWdataQ;
  assign cpuRdata = rdataQ;

  // R7
  snoop_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    snoopInv |=> !validQ[$past(snpIdx)]);

  // R8
  self_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopSrc == SELF_ID && !stb.fillLoad) |=> $stable(validQ));

  // R6
  store_no_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.storeUpd && !snoopValid) |=> $stable(validQ));

  // R3
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fillLoad && !snoopValid) |=> validQ[$past(reqIdx)]);

endmodule

// File: rtl/wtSnoopCache.sv
module wtSnoopCache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 3,
  parameter int SRC_W    = 2,
  parameter int CACHE_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [SRC_W-1:0]  snoopSrc
);

  dpStrobe_t stb;
  logic      lookupHit, reqWe;

  wtCacheCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cpuWe     (cpuWe),
    .lookupHit (lookupHit),
    .reqWe     (reqWe),
    .busGrant  (busGrant),
    .memAck    (memAck),
    .stb       (stb),
    .busReq    (busReq),
    .memReq    (memReq),
    .memWe     (memWe),
    .cpuReady  (cpuReady)
  );

  wtCacheData #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .SRC_W    (SRC_W),
    .CACHE_ID (CACHE_ID)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cpuWe      (cpuWe),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .memRdata   (memRdata),
    .snoopValid (snoopValid),
    .snoopAddr  (snoopAddr),
    .snoopSrc   (snoopSrc),
    .lookupHit  (lookupHit),
    .reqWe      (reqWe),
    .reqAddr    (memAddr),
    .reqWdata   (memWdata),
    .cpuRdata   (cpuRdata)
  );

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

endmodule

// File: tb/sim_wtSnoopCache.sv
module sim_wtSnoopCache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReq = 0, cpuWe = 0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuReady;
  logic [DW-1:0] cpuRdata;
  logic          busReq, busGrant = 0;
  logic          memReq, memWe, memAck = 0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata = '0;
  logic          snoopValid = 0;
  logic [AW-1:0] snoopAddr = '0;
  logic [SW-1:0] snoopSrc = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  logic [DW-1:0] memModel [256];
  bit            mValid [8];
  logic [4:0]    mTag [8];
  logic [DW-1:0] mData [8];
  bit            prevReady = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtSnoopCache u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGrant(busGrant), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .snoopSrc(snoopSrc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compared on every clock: grant rule and ready pulse width
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memReq) chk(busGrant, "R4", "memReq without grant", int'(busGrant), 1);
      if (prevReady) chk(!cpuReady, "R10", "ready longer than one cycle", int'(cpuReady), 0);
      prevReady = cpuReady;
    end
  end

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input int gDly, input int mLat, input string req);
    int idx = int'(a[2:0]);
    bit expHit = mValid[idx] && (mTag[idx] == a[7:3]);
    logic [DW-1:0] expData = expHit ? mData[idx] : memModel[a];
    bit done = 0, sawBus = 0, sawMem = 0;
    int cyc = 0, gCnt = 0, mCnt = 0;
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (memAck) memAck = 0;
      if (cpuReady) begin
        done = 1;
      end else begin
        if (busReq) sawBus = 1;
        if (busReq && !busGrant) begin
          if (gCnt >= gDly) busGrant = 1; else gCnt++;
        end
        if (memReq) begin
          if (!sawMem) begin
            chk(memWe == we, we ? "R4" : "R3", "memWe", int'(memWe), int'(we));
            chk(memAddr == a, we ? "R4" : "R3", "memAddr", int'(memAddr), int'(a));
            if (we) chk(memWdata == wd, "R4", "memWdata", int'(memWdata), int'(wd));
          end else begin
            chk(memAddr == a && memWe == we, "R9", "request changed before ack",
                int'(memAddr), int'(a));
          end
          sawMem = 1;
          if (mCnt >= mLat) begin
            memAck = 1;
            memRdata = memModel[a];
          end else mCnt++;
        end
      end
    end
    cpuReq = 0;
    busGrant = 0;
    chk(done, req, "no cpuReady", int'(done), 1);
    if (!we && expHit) begin
      chk(!sawBus && cyc == 1, "R2", "hit latency/bus use", cyc, 1);
    end else begin
      chk(sawBus && sawMem, we ? "R4" : "R3", "bus transaction", int'(sawMem), 1);
    end
    if (!we) chk(cpuRdata == expData, req, "load data", int'(cpuRdata), int'(expData));
    // update model
    if (we) begin
      memModel[a] = wd;
      if (expHit) mData[idx] = wd;
    end else if (!expHit) begin
      mValid[idx] = 1; mTag[idx] = a[7:3]; mData[idx] = memModel[a];
    end
    @(negedge clk);
    chk(!cpuReady && !busReq, "R10", "ready after completion", int'(cpuReady), 0);
  endtask

  task automatic expectHit(input logic [AW-1:0] a, input bit exp, input string req);
    int idx = int'(a[2:0]);
    bit h = mValid[idx] && (mTag[idx] == a[7:3]);
    chk(h == exp, req, "model hit state", int'(h), int'(exp));
  endtask

  task automatic snoop(input logic [SW-1:0] src, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int idx = int'(a[2:0]);
    @(negedge clk);
    snoopValid = 1; snoopAddr = a; snoopSrc = src;
    @(negedge clk);
    snoopValid = 0;
    if (src != 0) begin
      memModel[a] = d;
      if (mValid[idx] && mTag[idx] == a[7:3]) mValid[idx] = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 256; i++) memModel[i] = DW'(i * 37 + 16'h0100);
    for (int i = 0; i < 8; i++) begin mValid[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!cpuReady && !busReq && !memReq, "R1", "outputs after reset",
        int'({cpuReady, busReq, memReq}), 0);
    // R1 R3 first load misses
    access(0, 8'h05, '0, 2, 3, "R1");
    // R2 hit
    access(0, 8'h05, '0, 0, 0, "R2");
    // R4 R5 store hit, then echo of own write (R8)
    access(1, 8'h05, 16'hAAAA, 1, 2, "R4");
    snoop(0, 8'h05, 16'hAAAA);
    expectHit(8'h05, 1, "R8");
    access(0, 8'h05, '0, 0, 0, "R5");
    // R6 store miss does not allocate
    access(1, 8'h13, 16'h5151, 0, 1, "R6");
    expectHit(8'h13, 0, "R6");
    access(0, 8'h13, '0, 3, 0, "R6");
    // R7 foreign write invalidates, fresh value fetched
    snoop(1, 8'h05, 16'h1234);
    access(0, 8'h05, '0, 1, 1, "R7");
    // R11 same index other tag replaces line
    access(0, 8'h0D, '0, 0, 2, "R11");
    // R8 foreign write to other tag, same index: line stays
    snoop(2, 8'h05, 16'h7777);
    access(0, 8'h0D, '0, 0, 0, "R8");
    access(0, 8'h05, '0, 0, 0, "R11");
    // mixed traffic
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      a = {3'b000, lfsr[4:3], lfsr[7:5]};
      if (lfsr[1:0] == 2'b11) snoop(SW'(1 + lfsr[2]), a, DW'(lfsr * 11));
      else access(lfsr[0], a, DW'({lfsr, ~lfsr}), int'(lfsr[2:1]), int'(lfsr[6:5]), "R5");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule